// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block sits at the home node of a small shared-memory multiprocessor and keeps, for every memory block it owns, a coherence state (Uncached, Shared or Exclusive) together with a presence vector holding one bit per processor. Processor caches send it read misses, write misses and write-backs, each tagged with the requesting processor's number and a block index. The controller updates the entry, talks only to the caches named in the presence vector, and answers the requester with the block's data. The data itself lives in a small array inside the block.

Requests are handled strictly one at a time. When other copies must be removed, the controller sends one invalidate per cycle to each sharer in rising processor order, then the data reply. When a single cache owns a dirty copy, the controller asks that owner for it, waits for the owner's data on a separate response input, stores it in memory and only then replies. While a request is in flight, the request-ready output stays low.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, request-ready is high, no message is valid, every entry is Uncached with an empty presence vector, and the data word of block b equals b.
- R2: A read miss (kind 0) to an Uncached block produces, in the cycle after acceptance, one data reply (message kind 3) to the requester carrying memory's word. The entry becomes Shared with only the requester present.
- R3: A write miss (kind 1) to an Uncached block produces one data reply to the requester in the next cycle. The entry becomes Exclusive with the requester as the only, owning, member.
- R4: A read miss to a Shared block replies with memory's word and adds the requester to the presence vector. The block stays Shared.
- R5: A write miss to a Shared block sends one invalidate (kind 0) per cycle to each present processor other than the requester, in ascending number order, starting the cycle after acceptance. The data reply follows in the next cycle. If no other processor is present, the reply comes at once. The entry becomes Exclusive, owned by the requester.
- R6: A read miss to an Exclusive block sends a fetch (kind 1) to the owner and waits for the response input. The returned word is written to memory. In the following cycle it is replied to the requester. The entry becomes Shared with both the old owner and the requester present.
- R7: A write miss to an Exclusive block sends a fetch-and-invalidate (kind 2) to the owner and waits for the response. It then writes the returned word to memory and replies with it to the requester, which becomes the sole owner.
- R8: A write-back (kind 2) from the owner of an Exclusive block stores its data and makes the block Uncached with an empty presence vector. It emits no message. A write-back from any other processor, or to a block that is not Exclusive, changes nothing.
- R9: Request-ready is low from the cycle after a miss is accepted until the cycle after its data reply. Accepted write-backs leave it high.
- R10: Every message carries a 3-bit kind (0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply), a destination processor number, the block index and a data field. The data field is zero for every kind except the reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_src | input | $clog2(N_PROC) | Requesting processor number |
| req_blk | input | $clog2(N_BLK) | Block index |
| req_data | input | DATA_W | Write-back data |
| resp_valid | input | 1 | Owner's data returned after a fetch |
| resp_data | input | DATA_W | Owner's returned data |
| msg_valid | output | 1 | Outgoing message valid this cycle |
| msg_kind | output | 3 | Message kind |
| msg_dst | output | $clog2(N_PROC) | Destination processor |
| msg_blk | output | $clog2(N_BLK) | Block index of the message |
| msg_data | output | DATA_W | Data field (reply only) |

## Verification
A miss accepted at one clock edge makes its first message visible right after that edge. A reply with no prior traffic therefore comes one cycle after acceptance. Each invalidate adds one cycle. A fetch sits in that first cycle, and the reply follows one cycle after the edge that takes the owner's response. The bench queues the messages each request must produce in exactly this order, and compares each valid message on the falling edge as it appears. An unexpected message is counted as a failure, and so is an expected message still pending at the end. Ignored write-backs are proved by the absence of messages and by the data and presence lists that later requests reveal.

// File: rtl/dirc_pkg.sv
package dirc_pkg;

    typedef enum logic [1:0] {
        DS_UNC = 2'd0,
        DS_SHR = 2'd1,
        DS_EXC = 2'd2
    } dstate_e;

    typedef enum logic [1:0] {
        RQ_READ  = 2'd0,
        RQ_WRITE = 2'd1,
        RQ_WBACK = 2'd2
    } rqkind_e;

    typedef enum logic [2:0] {
        MK_INV      = 3'd0,
        MK_FETCH    = 3'd1,
        MK_FETCHINV = 3'd2,
        MK_DATA     = 3'd3
    } msgkind_e;

    typedef enum logic [2:0] {
        FS_IDLE  = 3'd0,
        FS_INVAL = 3'd1,
        FS_PULL  = 3'd2,
        FS_WAIT  = 3'd3,
        FS_REPLY = 3'd4
    } fsm_e;

endpackage

// File: rtl/dirc_first_set.sv
module dirc_first_set #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dirc_entry_store.sv
module dirc_entry_store
    import dirc_pkg::*;
#(
    parameter int N_PROC = 4,
    parameter int N_BLK  = 8,
    localparam int BW = (N_BLK > 1) ? $clog2(N_BLK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BW-1:0]     rd_blk,
    output dstate_e           rd_state,
    output logic [N_PROC-1:0] rd_sharers,
    input  logic              wr_en,
    input  logic [BW-1:0]     wr_blk,
    input  dstate_e           wr_state,
    input  logic [N_PROC-1:0] wr_sharers
);
    dstate_e           state_q [N_BLK];
    logic [N_PROC-1:0] pres_q  [N_BLK];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < N_BLK; b++) begin
                state_q[b] <= DS_UNC;
                pres_q[b]  <= '0;
            end
        end else if (wr_en) begin
            state_q[wr_blk] <= wr_state;
            pres_q[wr_blk]  <= wr_sharers;
        end
    end

    assign rd_state   = state_q[rd_blk];
    assign rd_sharers = pres_q[rd_blk];

    AST_EXC_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_state == DS_EXC |-> $countones(wr_sharers) == 1); // R3
    AST_UNC_EMPTY: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_state == DS_UNC |-> wr_sharers == '0); // R8
    AST_SHR_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_state == DS_SHR |-> wr_sharers != '0); // R4
endmodule

// File: rtl/dirc_data_store.sv
module dirc_data_store #(
    parameter int N_BLK  = 8,
    parameter int DATA_W = 16,
    localparam int BW = (N_BLK > 1) ? $clog2(N_BLK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BW-1:0]     rd_blk,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [BW-1:0]     wr_blk,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] word_q [N_BLK];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < N_BLK; b++) begin
                word_q[b] <= DATA_W'(b);
            end
        end else if (wr_en) begin
            word_q[wr_blk] <= wr_data;
        end
    end

    assign rd_data = word_q[rd_blk];
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dirc_pkg::*;
#(
    parameter int N_PROC = 4,
    parameter int N_BLK  = 8,
    parameter int DATA_W = 16,
    localparam int IW = (N_PROC > 1) ? $clog2(N_PROC) : 1,
    localparam int BW = (N_BLK > 1) ? $clog2(N_BLK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [IW-1:0]     req_src,
    input  logic [BW-1:0]     req_blk,
    input  logic [DATA_W-1:0] req_data,
    input  logic              resp_valid,
    input  logic [DATA_W-1:0] resp_data,
    output logic              msg_valid,
    output logic [2:0]        msg_kind,
    output logic [IW-1:0]     msg_dst,
    output logic [BW-1:0]     msg_blk,
    output logic [DATA_W-1:0] msg_data
);
    fsm_e              st, st_n;
    logic [IW-1:0]     cur_src;
    logic [BW-1:0]     cur_blk;
    logic [N_PROC-1:0] inv_mask, mask_n;
    logic              pull_inv, pull_inv_n;
    logic [IW-1:0]     owner, owner_n;
    logic              cap;

    dstate_e           ent_rst;
    logic [N_PROC-1:0] ent_rsh;
    logic              ent_we;
    logic [BW-1:0]     ent_wblk;
    dstate_e           ent_wst;
    logic [N_PROC-1:0] ent_wsh;

    logic [DATA_W-1:0] mem_rdata;
    logic              mem_we;
    logic [BW-1:0]     mem_wblk;
    logic [DATA_W-1:0] mem_wdata;

    logic              own_found, inv_found;
    logic [IW-1:0]     own_idx, inv_idx;
    logic [N_PROC-1:0] src_bit, cur_bit;
    rqkind_e           kind;
    msgkind_e          mk;

    assign kind    = rqkind_e'(req_kind);
    assign src_bit = N_PROC'(1) << req_src;
    assign cur_bit = N_PROC'(1) << cur_src;

    dirc_entry_store #(.N_PROC(N_PROC), .N_BLK(N_BLK)) u_dir (
        .clk(clk), .rst(rst),
        .rd_blk(req_blk), .rd_state(ent_rst), .rd_sharers(ent_rsh),
        .wr_en(ent_we), .wr_blk(ent_wblk), .wr_state(ent_wst), .wr_sharers(ent_wsh)
    );

    dirc_data_store #(.N_BLK(N_BLK), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst(rst),
        .rd_blk(cur_blk), .rd_data(mem_rdata),
        .wr_en(mem_we), .wr_blk(mem_wblk), .wr_data(mem_wdata)
    );

    dirc_first_set #(.N(N_PROC)) u_own (.vec(ent_rsh),  .found(own_found), .idx(own_idx));
    dirc_first_set #(.N(N_PROC)) u_inv (.vec(inv_mask), .found(inv_found), .idx(inv_idx));

    always_comb begin
        st_n       = st;
        cap        = 1'b0;
        mask_n     = inv_mask;
        pull_inv_n = pull_inv;
        owner_n    = owner;
        ent_we     = 1'b0;
        ent_wblk   = req_blk;
        ent_wst    = DS_UNC;
        ent_wsh    = '0;
        mem_we     = 1'b0;
        mem_wblk   = req_blk;
        mem_wdata  = req_data;
        unique case (st)
            FS_IDLE: begin
                if (req_valid) begin
                    cap = 1'b1;
                    case (kind)
                        RQ_READ: begin
                            if (ent_rst == DS_EXC) begin
                                owner_n    = own_idx;
                                pull_inv_n = 1'b0;
                                st_n       = FS_PULL;
                            end else begin
                                ent_we  = 1'b1;
                                ent_wst = DS_SHR;
                                ent_wsh = (ent_rst == DS_SHR) ? (ent_rsh | src_bit) : src_bit;
                                st_n    = FS_REPLY;
                            end
                        end
                        RQ_WRITE: begin
                            if (ent_rst == DS_EXC) begin
                                owner_n    = own_idx;
                                pull_inv_n = 1'b1;
                                st_n       = FS_PULL;
                            end else begin
                                ent_we  = 1'b1;
                                ent_wst = DS_EXC;
                                ent_wsh = src_bit;
                                if (ent_rst == DS_SHR && (ent_rsh & ~src_bit) != '0) begin
                                    mask_n = ent_rsh & ~src_bit;
                                    st_n   = FS_INVAL;
                                end else begin
                                    st_n = FS_REPLY;
                                end
                            end
                        end
                        RQ_WBACK: begin
                            if (ent_rst == DS_EXC && ent_rsh == src_bit) begin
                                ent_we  = 1'b1;
                                ent_wst = DS_UNC;
                                ent_wsh = '0;
                                mem_we  = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            FS_INVAL: begin
                mask_n = inv_mask & ~(N_PROC'(1) << inv_idx);
                if (mask_n == '0) st_n = FS_REPLY;
            end
            FS_PULL: st_n = FS_WAIT;
            FS_WAIT: begin
                if (resp_valid) begin
                    mem_we    = 1'b1;
                    mem_wblk  = cur_blk;
                    mem_wdata = resp_data;
                    ent_we    = 1'b1;
                    ent_wblk  = cur_blk;
                    if (pull_inv) begin
                        ent_wst = DS_EXC;
                        ent_wsh = cur_bit;
                    end else begin
                        ent_wst = DS_SHR;
                        ent_wsh = cur_bit | (N_PROC'(1) << owner);
                    end
                    st_n = FS_REPLY;
                end
            end
            FS_REPLY: st_n = FS_IDLE;
            default:  st_n = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= FS_IDLE;
            cur_src  <= '0;
            cur_blk  <= '0;
            inv_mask <= '0;
            pull_inv <= 1'b0;
            owner    <= '0;
        end else begin
            st       <= st_n;
            inv_mask <= mask_n;
            pull_inv <= pull_inv_n;
            owner    <= owner_n;
            if (cap) begin
                cur_src <= req_src;
                cur_blk <= req_blk;
            end
        end
    end

    always_comb begin
        msg_valid = 1'b0;
        mk        = MK_INV;
        msg_dst   = '0;
        msg_data  = '0;
        case (st)
            FS_INVAL: begin
                msg_valid = 1'b1;
                mk        = MK_INV;
                msg_dst   = inv_idx;
            end
            FS_PULL: begin
                msg_valid = 1'b1;
                mk        = pull_inv ? MK_FETCHINV : MK_FETCH;
                msg_dst   = owner;
            end
            FS_REPLY: begin
                msg_valid = 1'b1;
                mk        = MK_DATA;
                msg_dst   = cur_src;
                msg_data  = mem_rdata;
            end
            default: ;
        endcase
    end

    assign msg_kind  = mk;
    assign msg_blk   = cur_blk;
    assign req_ready = (st == FS_IDLE);

    AST_REPLY_FREES: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_kind == 3'd3 |=> req_ready); // R9
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> msg_kind <= 3'd3); // R10
    AST_NODATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_kind != 3'd3 |-> msg_data == '0); // R10
    AST_INV_ASCENDING: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_kind == 3'd0 && $past(msg_valid && msg_kind == 3'd0)
        |-> msg_dst > $past(msg_dst)); // R5
    AST_INV_NOT_SELF: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_kind == 3'd0 |-> msg_dst != cur_src); // R5
    AST_INVAL_HAS_TARGET: assert property (@(posedge clk) disable iff (rst)
        st == FS_INVAL |-> inv_found); // R5
    AST_EXC_OWNER_KNOWN: assert property (@(posedge clk) disable iff (rst)
        st == FS_IDLE && req_valid && ent_rst == DS_EXC |-> own_found); // R6
    AST_FETCH_THEN_WAIT: assert property (@(posedge clk) disable iff (rst)
        msg_valid && (msg_kind == 3'd1 || msg_kind == 3'd2) |=> !msg_valid && !req_ready); // R9
    AST_MISS_BUSY: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_kind != 2'd2 && req_kind != 2'd3 |=> !req_ready); // R9
endmodule

// File: tb/sim_dir_home_ctrl.sv
module sim_dir_home_ctrl;
    localparam int NP = 4;
    localparam int NB = 8;
    localparam int DW = 16;
    localparam int IW = 2;
    localparam int BW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [IW-1:0] req_src = '0;
    logic [BW-1:0] req_blk = '0;
    logic [DW-1:0] req_data = '0;
    logic          resp_valid = 1'b0;
    logic [DW-1:0] resp_data = '0;
    logic          msg_valid;
    logic [2:0]    msg_kind;
    logic [IW-1:0] msg_dst;
    logic [BW-1:0] msg_blk;
    logic [DW-1:0] msg_data;

    always #2 clk = ~clk;

    dir_home_ctrl #(.N_PROC(NP), .N_BLK(NB), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dst(msg_dst),
        .msg_blk(msg_blk), .msg_data(msg_data)
    );

    typedef struct packed {
        logic [2:0]    k;
        logic [IW-1:0] d;
        logic [BW-1:0] b;
        logic [DW-1:0] v;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    task automatic want(input logic [2:0] k, input int d, input int b,
                        input logic [DW-1:0] v, input string tag);
        exp_t e;
        e.k = k; e.d = IW'(d); e.b = BW'(b); e.v = v;
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && msg_valid) begin
            checks++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL unexpected message: got kind=%0d dst=%0d blk=%0d data=%h expected none",
                         msg_kind, msg_dst, msg_blk, msg_data);
            end else begin
                exp_t  e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                if (msg_kind !== e.k || msg_dst !== e.d || msg_blk !== e.b || msg_data !== e.v) begin
                    fails++;
                    $display("FAIL %s: got kind=%0d dst=%0d blk=%0d data=%h expected kind=%0d dst=%0d blk=%0d data=%h",
                             t, msg_kind, msg_dst, msg_blk, msg_data, e.k, e.d, e.b, e.v);
                end
            end
        end
    end

    // issue one request; for misses also check ready drops (R9)
    task automatic send(input int kind, input int src, input int blk, input logic [DW-1:0] data);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 2'(kind);
        req_src   = IW'(src);
        req_blk   = BW'(blk);
        req_data  = data;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        if (kind == 2) check_bit("R9 ready after write-back", req_ready, 1'b1);
        else           check_bit("R9 ready low during miss", req_ready, 1'b0);
    endtask

    // owner returns data while the controller waits after a fetch
    task automatic owner_data(input logic [DW-1:0] v);
        repeat (2) @(negedge clk);
        resp_valid = 1'b1;
        resp_data  = v;
        @(negedge clk);
        resp_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check_bit("R1 ready after reset", req_ready, 1'b1);
        check_bit("R1 no message after reset", msg_valid, 1'b0);

        // R2: read to uncached block 2, reply carries reset word 2
        want(3'd3, 1, 2, 16'd2, "R2 read uncached reply");
        send(0, 1, 2, '0);
        // R4: further readers join
        want(3'd3, 3, 2, 16'd2, "R4 read shared reply p3");
        send(0, 3, 2, '0);
        want(3'd3, 0, 2, 16'd2, "R4 read shared reply p0");
        send(0, 0, 2, '0);
        // R5: write by p3 invalidates p0 then p1, then reply
        want(3'd0, 0, 2, 16'd0, "R5 invalidate p0");
        want(3'd0, 1, 2, 16'd0, "R5 invalidate p1");
        want(3'd3, 3, 2, 16'd2, "R5 reply after invalidates");
        send(1, 3, 2, '0);
        // R6: read of exclusive block fetches from owner p3
        want(3'd1, 3, 2, 16'd0, "R6 fetch to owner");
        want(3'd3, 1, 2, 16'hA5A5, "R6 reply with owner data");
        send(0, 1, 2, '0);
        owner_data(16'hA5A5);
        // R6: both old owner and reader now present; memory holds A5A5
        want(3'd0, 1, 2, 16'd0, "R6 old reader invalidated");
        want(3'd0, 3, 2, 16'd0, "R6 old owner kept as sharer");
        want(3'd3, 2, 2, 16'hA5A5, "R6 memory updated");
        send(1, 2, 2, '0);

        // R3: write to uncached block 6
        want(3'd3, 0, 6, 16'd6, "R3 write uncached reply");
        send(1, 0, 6, '0);
        // R7: write to exclusive: fetch-and-invalidate to owner p0
        want(3'd2, 0, 6, 16'd0, "R7 fetch-invalidate to owner");
        want(3'd3, 1, 6, 16'h0C0C, "R7 reply with owner data");
        send(1, 1, 6, '0);
        owner_data(16'h0C0C);
        // R7: p1 is new owner
        want(3'd1, 1, 6, 16'd0, "R7 new owner fetched");
        want(3'd3, 2, 6, 16'h7777, "R7 reply after fetch");
        send(0, 2, 6, '0);
        owner_data(16'h7777);

        // R8: write-back to uncached block is ignored
        send(2, 1, 5, 16'hBEEF);
        want(3'd3, 0, 5, 16'd5, "R8 ignored write-back kept memory");
        send(0, 0, 5, '0);

        // R8: non-owner write-back ignored, owner write-back takes effect
        want(3'd3, 2, 4, 16'd4, "R3 write uncached block 4");
        send(1, 2, 4, '0);
        send(2, 1, 4, 16'hDEAD);
        send(2, 2, 4, 16'h1234);
        want(3'd3, 3, 4, 16'h1234, "R8 owner write-back stored, block uncached");
        send(0, 3, 4, '0);
        want(3'd0, 3, 4, 16'd0, "R8 presence cleared by write-back");
        want(3'd3, 0, 4, 16'h1234, "R5 reply block 4");
        send(1, 0, 4, '0);

        // R5: sole sharer upgrading gets reply at once
        want(3'd3, 0, 7, 16'd7, "R2 read block 7");
        send(0, 0, 7, '0);
        want(3'd3, 0, 7, 16'd7, "R5 upgrade with no other sharer");
        send(1, 0, 7, '0);

        repeat (6) @(negedge clk);
        check_bit("R10 all expected messages seen", expq.size() == 0, 1'b1);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule